// File: doc/BRIEF.md
# Processor Interrupt Recognition Unit

This unit stands between a processor execution core and two asynchronous interrupt lines. It decides at which instruction boundary an interrupt is taken. A maskable line is level-sensitive and gated by the core's interrupt-enable flag. A non-maskable line is edge-sensitive and cannot be masked. Both lines pass through a synchronizer. Each must then stay at its level for a minimum number of clocks before it can be recognized.

The core strobes `bound_i` at every instruction boundary, and at every iteration of a repeated string operation. It raises `defer_i` with that strobe when the finishing instruction loaded the stack segment or set the interrupt-enable flag. A maskable interrupt starts two acknowledge bus handshakes and captures the vector from the data input at the end of the second. A non-maskable interrupt uses fixed vector 2 with no bus cycles. After a non-maskable interrupt is taken, further non-maskable interrupts are held off until the core signals a return from interrupt. One edge seen during that time is remembered.

Top module: `intr_gate`

## Requirements
- R1: For a boundary sampled at rising edge E, the maskable request qualifies only if `mreq_i` was sampled high at every edge from E-10 to E-3. That is two synchronizer stages followed by eight qualification clocks.
- R2: When `ie_flag_i` is 0 at a boundary, a qualified maskable request does not start acknowledge cycles. The request stays pending and can be taken at a later enabled boundary.
- R3: A taken maskable request drives `ack_req_o` high with `ack_sel_o` = 0 (first cycle) until `ack_done_i`. It then drives `ack_sel_o` = 1 (second cycle) until `ack_done_i`. On that second completion edge, `ack_data_i` is latched into `vec_o` and `take_o` pulses for one cycle.
- R4: A non-maskable edge is recorded at edge k only if `nmreq_i` was sampled low at edges k-17 to k-10 and high at edges k-9 to k-2. The recorded edge can be taken at a boundary from edge k+1 on.
- R5: A taken non-maskable request pulses `take_o` with `vec_o` = 2 one cycle after the boundary edge. It does not raise `ack_req_o`.
- R6: After a non-maskable request is taken, no other non-maskable request is taken until `iret_i` is strobed.
- R7: Any number of recorded edges during the blocked window leave exactly one pending. That edge is taken at the first eligible boundary after `iret_i`.
- R8: Interrupts are taken only on a cycle with `bound_i` = 1 and `defer_i` = 0. A boundary flagged with `defer_i` takes nothing, so recognition moves to the following boundary.
- R9: When both requests are eligible at the same boundary, the non-maskable request is taken. The maskable request remains pending while `mreq_i` stays high.
- R10: During and right after reset, `take_o`, `ack_req_o`, `ack_sel_o` and `vec_o` are 0. Boundaries are ignored while an acknowledge sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Maskable interrupt request, asynchronous, level |
| nmreq_i | input | 1 | Non-maskable interrupt request, asynchronous, rising edge |
| ie_flag_i | input | 1 | Core interrupt-enable flag |
| bound_i | input | 1 | Instruction boundary strobe |
| defer_i | input | 1 | Finishing instruction loaded stack segment or set enable flag |
| iret_i | input | 1 | Return-from-interrupt strobe |
| ack_done_i | input | 1 | Current acknowledge bus cycle completes |
| ack_data_i | input | 8 | Vector data bus sampled at end of second acknowledge |
| take_o | output | 1 | One-cycle pulse: interrupt taken |
| vec_o | output | 8 | Vector of the most recently taken interrupt |
| ack_req_o | output | 1 | Acknowledge bus cycle requested |
| ack_sel_o | output | 1 | 0 = first acknowledge cycle, 1 = second |

## Verification
The assertions check these rules on every cycle:
- A take only follows an undeferred boundary or the second acknowledge completion.
- The first acknowledge always leads into the second.
- The vector matches the data sampled on the final completion.
- Non-maskable takes carry vector 2 and no bus request.
- Acknowledge cycles start only with the enable flag set.

The qualification windows, the nesting block until return and the single remembered edge depend on long input histories. Only the bench's directed scenarios and its cycle-level reference model show those.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK1 = 2'd1,
    SEQ_ACK2 = 2'd2
  } seq_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/intr_lvl_qual.sv
module intr_lvl_qual #(
  parameter int QUAL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!lvl_i)             cnt_q <= '0;
    else if (cnt_q != CW'(QUAL)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CW'(QUAL));
endmodule

// File: rtl/intr_edge_qual.sv
module intr_edge_qual #(
  parameter int QUAL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic det_o
);
  localparam int CW = $clog2(QUAL + 1);
  logic [CW-1:0] lo_cnt_q, hi_cnt_q;
  logic          armed_q;

  // armed_q: the most recent low run lasted at least QUAL clocks
  assign det_o = lvl_i && armed_q && (hi_cnt_q == CW'(QUAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
      armed_q  <= 1'b0;
    end else if (lvl_i) begin
      lo_cnt_q <= '0;
      if (hi_cnt_q != CW'(QUAL)) hi_cnt_q <= hi_cnt_q + 1'b1;
      if (det_o) armed_q <= 1'b0;
    end else begin
      hi_cnt_q <= '0;
      if (lo_cnt_q != CW'(QUAL)) lo_cnt_q <= lo_cnt_q + 1'b1;
      armed_q <= (lo_cnt_q >= CW'(QUAL - 1));
    end
  end
endmodule

// File: rtl/intr_ack_seq.sv
module intr_ack_seq
  import intr_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic idle_o,
  output logic req_o,
  output logic sel_o,
  output logic fin_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (start_i) st_d = SEQ_ACK1;
      SEQ_ACK1: if (done_i)  st_d = SEQ_ACK2;
      SEQ_ACK2: if (done_i)  st_d = SEQ_IDLE;
      default:               st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o = (st_q == SEQ_IDLE);
  assign req_o  = (st_q == SEQ_ACK1) || (st_q == SEQ_ACK2);
  assign sel_o  = (st_q == SEQ_ACK2);
  assign fin_o  = (st_q == SEQ_ACK2) && done_i;
endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int VEC_W       = 8,
  parameter int QUAL_CYC    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_VEC     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreq_i,
  input  logic             nmreq_i,
  input  logic             ie_flag_i,
  input  logic             bound_i,
  input  logic             defer_i,
  input  logic             iret_i,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ack_req_o,
  output logic             ack_sel_o
);
  localparam int NSRC = 2;
  localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

  logic [NSRC-1:0] raw, syn;
  logic m_qual, n_det;
  logic seq_idle, seq_fin;
  logic can_take, nmi_take, m_take;
  logic nmi_busy_q, nmi_pend_q;
  logic take_q;
  logic [VEC_W-1:0] vec_q;

  assign raw = {nmreq_i, mreq_i};

  intr_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  intr_lvl_qual #(.QUAL(QUAL_CYC)) u_mqual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (syn[0]),
    .qual_o(m_qual)
  );

  intr_edge_qual #(.QUAL(QUAL_CYC)) u_nqual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (syn[1]),
    .det_o (n_det)
  );

  // boundaries are ignored while an acknowledge sequence owns the bus
  assign can_take = bound_i && !defer_i && seq_idle;
  assign nmi_take = can_take && nmi_pend_q && !nmi_busy_q;
  assign m_take   = can_take && !nmi_take && m_qual && ie_flag_i;

  intr_ack_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(m_take),
    .done_i (ack_done_i),
    .idle_o (seq_idle),
    .req_o  (ack_req_o),
    .sel_o  (ack_sel_o),
    .fin_o  (seq_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_busy_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      if (nmi_take)    nmi_busy_q <= 1'b1;
      else if (iret_i) nmi_busy_q <= 1'b0;
      // single pending slot: further edges merge into it
      if (n_det)         nmi_pend_q <= 1'b1;
      else if (nmi_take) nmi_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= nmi_take || seq_fin;
      if (nmi_take)     vec_q <= NMI_CODE;
      else if (seq_fin) vec_q <= ack_data_i;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ie_flag_i,
  input logic             bound_i,
  input logic             defer_i,
  input logic             ack_done_i,
  input logic [VEC_W-1:0] ack_data_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ack_req_o,
  input logic             ack_sel_o
);
  p_take_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($past(bound_i && !defer_i) || $past(ack_sel_o && ack_done_i)));

  p_ack_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !ack_sel_o && ack_done_i) |=> (ack_req_o && ack_sel_o));

  p_ack_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_sel_o && ack_done_i) |=> (take_o && vec_o == $past(ack_data_i)));

  p_sel_in_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_sel_o |-> ack_req_o);

  p_nmi_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !$past(ack_sel_o)) |-> (vec_o == VEC_W'(NMI_VEC) && !ack_req_o));

  p_ie_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(ie_flag_i && bound_i && !defer_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r10: assert (!take_o && !ack_req_o && !ack_sel_o && vec_o == '0);
    end
  end
endmodule

bind intr_gate intr_gate_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ie_flag_i (ie_flag_i),
  .bound_i   (bound_i),
  .defer_i   (defer_i),
  .ack_done_i(ack_done_i),
  .ack_data_i(ack_data_i),
  .take_o    (take_o),
  .vec_o     (vec_o),
  .ack_req_o (ack_req_o),
  .ack_sel_o (ack_sel_o)
);

// File: tb/sim_intr_gate.sv
`timescale 1ns/1ps
module sim_intr_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq = 0, nmreq = 0, ie = 0, bnd = 0, dfr = 0, iret = 0, adone = 0;
  logic [7:0] adata = '0;
  logic take, ack_req, ack_sel;
  logic [7:0] vec;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  intr_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .mreq_i(mreq), .nmreq_i(nmreq),
    .ie_flag_i(ie), .bound_i(bnd), .defer_i(dfr), .iret_i(iret),
    .ack_done_i(adone), .ack_data_i(adata),
    .take_o(take), .vec_o(vec), .ack_req_o(ack_req), .ack_sel_o(ack_sel)
  );

  // reference model built from the requirements
  logic [9:0]  mh;   // mh[i] = mreq at edge E-1-i
  logic [16:0] nh;   // nh[i] = nmreq at edge k-1-i
  logic [1:0]  e_st;
  logic        e_busy, e_pend, e_take;
  logic [7:0]  e_vec;

  function automatic logic m_qualified(input logic [9:0] h);
    return &h[9:2];                       // R1 window E-10..E-3
  endfunction

  function automatic logic n_edge(input logic [16:0] h);
    return (&h[8:1]) && !(|h[16:9]);      // R4 high k-9..k-2, low k-17..k-10
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic nt, mt, det;
    if (!rst_n) begin
      mh <= '0; nh <= '0; e_st <= 2'd0; e_busy <= 1'b0; e_pend <= 1'b0;
      e_take <= 1'b0; e_vec <= '0;
    end else begin
      det = n_edge(nh);
      nt  = (e_st == 2'd0) && bnd && !dfr && e_pend && !e_busy;
      mt  = (e_st == 2'd0) && bnd && !dfr && !nt && m_qualified(mh) && ie;
      e_take <= 1'b0;
      case (e_st)
        2'd0: if (mt) e_st <= 2'd1;
        2'd1: if (adone) e_st <= 2'd2;
        default: if (adone) begin e_st <= 2'd0; e_take <= 1'b1; e_vec <= adata; end
      endcase
      if (nt) begin e_take <= 1'b1; e_vec <= 8'd2; end
      if (nt) e_busy <= 1'b1; else if (iret) e_busy <= 1'b0;
      if (det) e_pend <= 1'b1; else if (nt) e_pend <= 1'b0;
      mh <= {mh[8:0], mreq};
      nh <= {nh[15:0], nmreq};
    end
  end

  int ntake = 0;
  task automatic tick(input string tag);
    @(negedge clk);
    nchk++;
    if (take) ntake++;
    if (take !== e_take || vec !== e_vec || ack_req !== (e_st != 2'd0) || ack_sel !== (e_st == 2'd2)) begin
      nfail++;
      $display("FAIL %s: take=%0b vec=%02h req=%0b sel=%0b expected take=%0b vec=%02h req=%0b sel=%0b",
               tag, take, vec, ack_req, ack_sel, e_take, e_vec, e_st != 2'd0, e_st == 2'd2);
    end
  endtask

  task automatic check_cnt(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: take count %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R10: watchdog expired, actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); nchk++;
      if (take !== 1'b0 || ack_req !== 1'b0 || ack_sel !== 1'b0 || vec !== 8'h00) begin
        nfail++;
        $display("FAIL R10: take=%0b req=%0b sel=%0b vec=%02h expected 0 0 0 00", take, ack_req, ack_sel, vec);
      end
    end
    rst_n = 1'b1;
    run("R10", 24);

    // R1 qualification and R3 handshake
    ie = 1; mreq = 1; bnd = 1; ntake = 0;
    run("R1", 14);
    bnd = 0; adone = 1; adata = 8'hA5;
    run("R3", 1);
    adone = 0; run("R3", 3);
    adone = 1; adata = 8'h3C; run("R3", 2);
    adone = 0; mreq = 0; run("R3", 12);
    check_cnt("R3", ntake, 1);

    // R2 masked: nothing happens
    ie = 0; mreq = 1; bnd = 1; ntake = 0;
    run("R2", 20);
    check_cnt("R2", ntake, 0);
    bnd = 0; ie = 1; run("R2", 1);
    bnd = 1; run("R2", 1); bnd = 0; adone = 1; run("R2", 3); adone = 0;
    mreq = 0; run("R2", 12);

    // R8 deferred boundary
    mreq = 1; run("R8", 12);
    bnd = 1; dfr = 1; run("R8", 1);
    bnd = 0; dfr = 0; run("R8", 2);
    bnd = 1; run("R8", 1); bnd = 0; adone = 1; run("R8", 3); adone = 0;
    mreq = 0; run("R8", 12);

    // R4 short pulse rejected, then full edge taken (R5)
    ntake = 0; bnd = 1;
    nmreq = 1; run("R4", 5); nmreq = 0; run("R4", 12);
    check_cnt("R4", ntake, 0);
    bnd = 0; nmreq = 1; run("R5", 12);
    bnd = 1; run("R5", 2);
    check_cnt("R5", ntake, 1);
    bnd = 0; nmreq = 0; run("R5", 10);

    // R6/R7 blocked until return, one edge remembered
    ntake = 0; bnd = 1;
    nmreq = 1; run("R6", 12); nmreq = 0; run("R6", 12);
    nmreq = 1; run("R6", 12); nmreq = 0; run("R6", 12);
    check_cnt("R6", ntake, 0);
    bnd = 0; iret = 1; run("R7", 1); iret = 0;
    bnd = 1; run("R7", 6);
    check_cnt("R7", ntake, 1);
    bnd = 0; iret = 1; run("R7", 1); iret = 0; bnd = 1; run("R7", 6);
    check_cnt("R7", ntake, 1);

    // R9 simultaneous: non-maskable first, maskable after
    bnd = 0; ntake = 0; iret = 1; run("R9", 1); iret = 0;
    mreq = 1; nmreq = 1; run("R9", 12);
    bnd = 1; run("R9", 1); bnd = 0; run("R9", 1);
    bnd = 1; run("R9", 1); bnd = 0; adone = 1; adata = 8'h77; run("R9", 3);
    adone = 0; mreq = 0; nmreq = 0; iret = 1; run("R9", 1); iret = 0; run("R9", 12);
    check_cnt("R9", ntake, 2);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 16) == 0) mreq = ~mreq;
      if (($urandom % 14) == 0) nmreq = ~nmreq;
      ie    = ($urandom % 8) != 0;
      bnd   = ($urandom % 3) == 0;
      dfr   = ($urandom % 6) == 0;
      iret  = ($urandom % 25) == 0;
      adone = ($urandom % 2) == 0;
      adata = 8'($urandom);
      tick("R1");
    end

    summary();
    $finish;
  end
endmodule